// File: doc/BRIEF.md
# Scanline-counting interrupt generator

This block counts rendered scanlines for a cartridge controller and raises an interrupt request to the CPU when a programmed count runs out. The CPU programs it through four register writes on a 16-bit address bus. One write loads the running counter directly. One sets the reload value. One turns counting on. One turns counting off and drops any pending request.

The video side supplies three signals: a one-cycle strobe once per scanline, the current scanline number and a rendering-enabled flag. A strobe counts only when it falls on a visible line, rendering is on and counting is enabled. When the counter is already zero at such a strobe, it reloads from the reload value and raises the request. Otherwise it decrements. The request is a level and stays high until the CPU acknowledges it.

Top module: `scanline_irq_gen`

## Requirements
- R1: A write whose address ANDed with 0xE001 equals 0xC000 loads the write data into the running counter on that clock edge.
- R2: A write whose address ANDed with 0xE001 equals 0xC001 stores the write data as the reload value; the running counter is not changed.
- R3: A write decoding to 0xE001 enables counting. A write decoding to 0xE000 disables counting and drives irq_o low on the following edge, even if an expiry occurs in the same cycle.
- R4: A scanline strobe is counted only when line_num_i is 239 or less, render_en_i is high and counting is enabled; any other strobe leaves the counter unchanged.
- R5: On a counted strobe, a counter value of zero reloads the counter from the reload value and sets irq_o. A nonzero counter value decrements by one.
- R6: Once set, irq_o stays high through further strobes and other writes until a write decoding to 0xE000.
- R7: The asynchronous active-low reset clears the enable, the counter, the reload value and irq_o.
- R8: The address decode uses only bits 15, 14, 13 and 0, so mirrored addresses behave the same. Writes decoding to 0x8000, 0x8001, 0xA000 or 0xA001 change nothing in the block.
- R9: If a counter-load write and a counted strobe occur in the same cycle, the write wins. The strobe is dropped, with no decrement, no reload and no interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | CPU register write strobe |
| wr_addr_i | input | 16 | CPU write address |
| wr_data_i | input | 8 | CPU write data |
| line_pulse_i | input | 1 | One-cycle strobe per scanline |
| line_num_i | input | 9 | Current scanline number |
| render_en_i | input | 1 | Rendering enabled flag |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, a 9-bit line number and a last visible line of 239. These defaults put the 239/240 qualification edge within reach, along with zero-valued counts and reloads that fire on every counted line. Mirrored addresses near the top of each decode window are also covered. Stimulus drives a counter-load write and a strobe in the same cycle to exercise the write-priority rule. Other stimulus lets an expiry coincide with an acknowledge.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;
  typedef enum logic [1:0] {
    OP_LOAD_CNT = 2'd0,
    OP_LOAD_RLD = 2'd1,
    OP_DISABLE  = 2'd2,
    OP_ENABLE   = 2'd3
  } reg_op_e;

  typedef struct packed {
    logic    hit;
    reg_op_e op;
  } reg_cmd_t;
endpackage

// File: rtl/scanline_irq_decode.sv
module scanline_irq_decode
  import scanline_irq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SEL_MASK = 16'hE001,
  parameter logic [ADDR_W-1:0] CNT_BASE = 16'hC000,
  parameter logic [ADDR_W-1:0] CTL_BASE = 16'hE000
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output reg_cmd_t          cmd_o
);
  logic [ADDR_W-1:0] masked;
  logic              odd;

  assign masked = wr_addr_i & SEL_MASK;
  assign odd    = wr_addr_i[0];

  always_comb begin
    cmd_o = '{hit: 1'b0, op: OP_LOAD_CNT};
    if (wr_en_i) begin
      if ((masked & ~ADDR_W'(1)) == CNT_BASE) begin
        cmd_o.hit = 1'b1;
        cmd_o.op  = odd ? OP_LOAD_RLD : OP_LOAD_CNT;
      end else if ((masked & ~ADDR_W'(1)) == CTL_BASE) begin
        cmd_o.hit = 1'b1;
        cmd_o.op  = odd ? OP_ENABLE : OP_DISABLE;
      end
    end
  end
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              rld_wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              step_i,
  output logic              fire_o
);
  logic [DATA_W-1:0] cnt_q, rld_q;
  logic              zero;
  logic              take;

  assign zero   = (cnt_q == '0);
  assign take   = step_i && !load_i;  // CPU load wins over strobe
  assign fire_o = take && zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      if (rld_wr_i) rld_q <= data_i;
      if (load_i)       cnt_q <= data_i;
      else if (take)    cnt_q <= zero ? rld_q : cnt_q - DATA_W'(1);
    end
  end

  a_r1_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(data_i));
  a_r2_rld_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rld_wr_i |=> rld_q == $past(data_i));
  a_r5_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && cnt_q == '0) |=> cnt_q == $past(rld_q));
  a_r5_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - DATA_W'(1));
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/scanline_irq_ctrl.sv
module scanline_irq_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_set_i,
  input  logic en_clr_i,
  input  logic fire_i,
  output logic en_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      if (en_clr_i)      en_o <= 1'b0;
      else if (en_set_i) en_o <= 1'b1;
      if (en_clr_i)      irq_o <= 1'b0;  // ack beats expiry
      else if (fire_i)   irq_o <= 1'b1;
    end
  end

  a_r3_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_clr_i |=> !irq_o && !en_o);
  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !en_clr_i) |=> irq_o);
  a_r5_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(fire_i));
endmodule

// File: rtl/scanline_irq_gen.sv
module scanline_irq_gen
  import scanline_irq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 239
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              line_pulse_i,
  input  logic [LINE_W-1:0] line_num_i,
  input  logic              render_en_i,
  output logic              irq_o
);
  localparam logic [LINE_W-1:0] LastLine = LINE_W'(LAST_LINE);

  reg_cmd_t cmd;
  logic     en, fire, step;

  scanline_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .cmd_o     (cmd)
  );

  assign step = line_pulse_i && render_en_i && en && (line_num_i <= LastLine);

  scanline_irq_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (cmd.hit && cmd.op == OP_LOAD_CNT),
    .rld_wr_i (cmd.hit && cmd.op == OP_LOAD_RLD),
    .data_i   (wr_data_i),
    .step_i   (step),
    .fire_o   (fire)
  );

  scanline_irq_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_set_i (cmd.hit && cmd.op == OP_ENABLE),
    .en_clr_i (cmd.hit && cmd.op == OP_DISABLE),
    .fire_i   (fire),
    .en_o     (en),
    .irq_o    (irq_o)
  );

  a_r4_qualify: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_pulse_i && (line_num_i > LastLine || !render_en_i)) |=> !$rose(irq_o));
  a_r8_no_side_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !cmd.hit && !line_pulse_i) |=> $stable(irq_o));
endmodule

// File: tb/scanline_irq_gen_test.sv
module scanline_irq_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        pulse = 1'b0;
  logic [8:0]  line = '0;
  logic        ren = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  scanline_irq_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .line_pulse_i(pulse), .line_num_i(line),
    .render_en_i(ren), .irq_o(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  data;
    logic        pl;
    logic [8:0]  ln;
    logic        rn;
    logic        exp_irq;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 16'hC001, 8'h03, 1'b0, 9'd0,   1'b1, 1'b0},  // R2 reload 3
    '{1'b1, 16'hC000, 8'h01, 1'b0, 9'd0,   1'b1, 1'b0},  // R1 count 1
    '{1'b1, 16'hE001, 8'h00, 1'b0, 9'd0,   1'b1, 1'b0},  // R3 enable
    '{1'b0, 16'h0000, 8'h00, 1'b1, 9'd10,  1'b1, 1'b0},  // R5 1->0
    '{1'b0, 16'h0000, 8'h00, 1'b1, 9'd11,  1'b1, 1'b1},  // R5 0 -> fire, 3
    '{1'b1, 16'hE000, 8'h00, 1'b0, 9'd0,   1'b1, 1'b0},  // R3 ack+disable
    '{1'b0, 16'h0000, 8'h00, 1'b1, 9'd20,  1'b1, 1'b0},  // R4 disabled
    '{1'b1, 16'hE001, 8'h00, 1'b0, 9'd0,   1'b1, 1'b0},
    '{1'b0, 16'h0000, 8'h00, 1'b1, 9'd240, 1'b1, 1'b0},  // R4 line 240 ignored
    '{1'b0, 16'h0000, 8'h00, 1'b1, 9'd5,   1'b0, 1'b0},  // R4 render off
    '{1'b0, 16'h0000, 8'h00, 1'b1, 9'd0,   1'b1, 1'b0},  // 3->2
    '{1'b0, 16'h0000, 8'h00, 1'b1, 9'd239, 1'b1, 1'b0},  // R4 239 counts 2->1
    '{1'b0, 16'h0000, 8'h00, 1'b1, 9'd1,   1'b1, 1'b0},  // 1->0
    '{1'b0, 16'h0000, 8'h00, 1'b1, 9'd2,   1'b1, 1'b1},  // R5 fire
    '{1'b0, 16'h0000, 8'h00, 1'b1, 9'd3,   1'b1, 1'b1},  // R6 sticky
    '{1'b1, 16'hC001, 8'h07, 1'b0, 9'd0,   1'b1, 1'b1},  // R6 sticky over write
    '{1'b1, 16'hE000, 8'h00, 1'b0, 9'd0,   1'b1, 1'b0},
    '{1'b1, 16'hDFFE, 8'h00, 1'b0, 9'd0,   1'b1, 1'b0},  // R8 mirror of count load
    '{1'b1, 16'hA001, 8'h00, 1'b0, 9'd0,   1'b1, 1'b0},  // R8 ignored
    '{1'b1, 16'h8001, 8'h00, 1'b0, 9'd0,   1'b1, 1'b0},  // R8 ignored
    '{1'b1, 16'hFFFF, 8'h00, 1'b0, 9'd0,   1'b1, 1'b0},  // R8 mirror enable
    '{1'b0, 16'h0000, 8'h00, 1'b1, 9'd7,   1'b1, 1'b1},  // fire, reload 7
    '{1'b1, 16'hFFFE, 8'h00, 1'b0, 9'd0,   1'b1, 1'b0},  // R8 mirror ack
    '{1'b1, 16'hE001, 8'h00, 1'b0, 9'd0,   1'b1, 1'b0},
    '{1'b1, 16'hC000, 8'h00, 1'b1, 9'd8,   1'b1, 1'b0},  // R9 load wins
    '{1'b0, 16'h0000, 8'h00, 1'b1, 9'd9,   1'b1, 1'b1}   // R9 count was 0
  };

  task automatic drive(input logic w, input logic [15:0] a, input logic [7:0] d,
                       input logic p, input logic [8:0] l, input logic r);
    wr_en = w; wr_addr = a; wr_data = d; pulse = p; line = l; ren = r;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; pulse = 1'b0;
  endtask

  task automatic check(input string req, input logic exp);
    n_chk++;
    if (irq !== exp) begin
      n_bad++;
      $display("FAIL %s: irq_o=%b expected %b", req, irq, exp);
    end
  endtask

  task automatic pulse_n(input int n);
    for (int k = 0; k < n; k++) drive(1'b0, 16'h0, 8'h0, 1'b1, 9'd50, 1'b1);
  endtask

  initial begin
    #200us;
    n_bad++;
    $display("FAIL watchdog: run hung");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].wr, VEC[i].addr, VEC[i].data, VEC[i].pl, VEC[i].ln, VEC[i].rn);
      check($sformatf("vector %0d", i), VEC[i].exp_irq);
    end

    // R9: after load-wins, counter reloaded from 7; no fire for 7 strobes
    drive(1'b1, 16'hE000, 8'h0, 1'b0, 9'd0, 1'b1);
    drive(1'b1, 16'hE001, 8'h0, 1'b0, 9'd0, 1'b1);
    pulse_n(7);
    check("R5 count down from 7", 1'b0);
    pulse_n(1);
    check("R5 fire after 8 strobes", 1'b1);

    // R3: ack in same cycle as expiry
    drive(1'b1, 16'hE000, 8'h0, 1'b0, 9'd0, 1'b1);
    drive(1'b1, 16'hC001, 8'h00, 1'b0, 9'd0, 1'b1);
    drive(1'b1, 16'hC000, 8'h00, 1'b0, 9'd0, 1'b1);
    drive(1'b1, 16'hE001, 8'h0, 1'b0, 9'd0, 1'b1);
    drive(1'b1, 16'hE000, 8'h0, 1'b1, 9'd30, 1'b1);
    check("R3 ack beats expiry", 1'b0);

    // R7: reset mid-run clears everything; latch 0 fires every strobe
    drive(1'b1, 16'hC001, 8'h05, 1'b0, 9'd0, 1'b1);
    drive(1'b1, 16'hC000, 8'h05, 1'b0, 9'd0, 1'b1);
    drive(1'b1, 16'hE001, 8'h0, 1'b0, 9'd0, 1'b1);
    pulse_n(6);
    check("R5 fire before reset", 1'b1);
    rst_n = 1'b0;
    #1;
    check("R7 async reset irq", 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    pulse_n(1);
    check("R7 enable cleared by reset", 1'b0);
    drive(1'b1, 16'hE001, 8'h0, 1'b0, 9'd0, 1'b1);
    pulse_n(1);
    check("R7 counter zero after reset", 1'b1);
    drive(1'b1, 16'hE000, 8'h0, 1'b0, 9'd0, 1'b1);
    drive(1'b1, 16'hE001, 8'h0, 1'b0, 9'd0, 1'b1);
    pulse_n(1);
    check("R7 reload zero after reset", 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule